// File: doc/BRIEF.md
# Retirement Load Value Re-Check

This block verifies, at the retirement point, that a load which ran ahead of older stores still holds a correct value. Instead of searching a queue of in-flight loads for matching store addresses, it takes the retiring load's address and the value the load originally consumed. It reads that address from memory a second time and compares the two values. Equal values let the load retire. Unequal values turn into a flush request for that load and everything younger, carrying the freshly read value as the corrected data.

Loads that the core can prove were never exposed to a read-after-write hazard are tagged with a skip bit. These retire one cycle after being offered and use no memory read. Because the check looks only at values, a store to the same address that wrote back the value already held there never causes a flush.

The core offers one record at a time, in program order, through a valid/ready pair. It must squash its younger work when the flush output fires.

Top module: `retire_load_verifier`

## Requirements
- R1: After reset, `rec_ready` is 1, and `mem_req`, `done_valid` and `flush_valid` are 0.
- R2: A record accepted with `rec_skip`=0 drives `mem_req`=1 and `mem_addr`=`rec_addr` in the accepting cycle. In the following cycle `rec_ready` is 0 and neither outcome is signalled.
- R3: If the value returned one cycle after the read equals the saved `rec_value`, then two cycles after acceptance `done_valid`=1 for one cycle, with `done_age` equal to the record's age and `done_data` equal to the saved value, and `flush_valid`=0.
- R4: If the returned value differs from the saved value, then two cycles after acceptance `flush_valid`=1 for one cycle, with `flush_age` equal to the record's age and `flush_data` equal to the re-read value, and `done_valid`=0.
- R5: The decision depends on values only. A load whose address was rewritten with its unchanged value retires without a flush.
- R6: A record accepted with `rec_skip`=1 issues no memory read. One cycle later it gives `done_valid`=1, with the record's age and `done_data`=`rec_value`, whatever memory holds.
- R7: While `flush_valid` is 1, `rec_ready` is 0 and an offered record issues no memory read.
- R8: In a cycle with `rec_ready`=1 and `rec_valid`=0, neither `done_valid` nor `flush_valid` is raised in the next cycle.
- R9: `done_valid` and `flush_valid` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | A retiring load record is offered |
| rec_skip | input | 1 | Load known safe; retire without a second read |
| rec_addr | input | ADDR_W | Load address |
| rec_value | input | DATA_W | Value the load originally used |
| rec_age | input | AGE_W | Program-order tag of the load |
| rec_ready | output | 1 | Record is accepted when high together with rec_valid |
| mem_req | output | 1 | Second-read request to memory |
| mem_addr | output | ADDR_W | Second-read address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_req |
| done_valid | output | 1 | Load may retire |
| done_age | output | AGE_W | Tag of the retiring load |
| done_data | output | DATA_W | Confirmed load value |
| flush_valid | output | 1 | Flush this load and all younger work |
| flush_age | output | AGE_W | Tag of the load that starts the flush |
| flush_data | output | DATA_W | Corrected value from the second read |

## Verification
The bench builds the block with a 4-bit address, an 8-bit data word and a 4-bit age. The 4-bit address lets a 16-word memory model in the bench cover every location, so random same-address store/load collisions are frequent. The narrow age wraps many times during a run, and the short data word lets the bench also hit value-equal rewrites. Directed cases cover the rewrite with an unchanged value, a skipped load whose stale value differs from memory, and a record offered while a flush is visible.

// File: rtl/retire_load_verifier.sv
module retire_load_verifier #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int AGE_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic              rec_skip,
  input  logic [ADDR_W-1:0] rec_addr,
  input  logic [DATA_W-1:0] rec_value,
  input  logic [AGE_W-1:0]  rec_age,
  output logic              rec_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done_valid,
  output logic [AGE_W-1:0]  done_age,
  output logic [DATA_W-1:0] done_data,
  output logic              flush_valid,
  output logic [AGE_W-1:0]  flush_age,
  output logic [DATA_W-1:0] flush_data
);

  logic              busy;
  logic              take;
  logic              differs;
  logic [AGE_W-1:0]  held_age;
  logic [DATA_W-1:0] held_value;

  assign rec_ready = !busy && !flush_valid;
  assign take      = rec_valid && rec_ready;
  assign mem_req   = take && !rec_skip;
  assign mem_addr  = rec_addr;
  assign differs   = held_value != mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      held_age    <= '0;
      held_value  <= '0;
      done_valid  <= 1'b0;
      done_age    <= '0;
      done_data   <= '0;
      flush_valid <= 1'b0;
      flush_age   <= '0;
      flush_data  <= '0;
    end else begin
      done_valid  <= 1'b0;
      flush_valid <= 1'b0;
      if (busy) begin
        busy <= 1'b0;
        if (differs) begin
          flush_valid <= 1'b1;
          flush_age   <= held_age;
          flush_data  <= mem_rdata;
        end else begin
          done_valid <= 1'b1;
          done_age   <= held_age;
          done_data  <= mem_rdata;
        end
      end else if (take) begin
        if (rec_skip) begin
          done_valid <= 1'b1;
          done_age   <= rec_age;
          done_data  <= rec_value;
        end else begin
          busy       <= 1'b1;
          held_age   <= rec_age;
          held_value <= rec_value;
        end
      end
    end
  end

endmodule

module retire_load_verifier_chk #(
  parameter int AGE_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rec_valid,
  input logic             rec_skip,
  input logic [AGE_W-1:0] rec_age,
  input logic             rec_ready,
  input logic             mem_req,
  input logic             done_valid,
  input logic [AGE_W-1:0] done_age,
  input logic             flush_valid
);

  // R9
  excl_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_valid && flush_valid));

  // R7
  flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (!rec_ready && !mem_req));

  // R2
  reread_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (!rec_ready && !done_valid && !flush_valid));

  // R4
  reread_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> ##1 (done_valid || flush_valid));

  // R6
  skip_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready && rec_skip) |=> (done_valid && done_age == $past(rec_age)));

  // R6
  skip_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready && rec_skip) |-> !mem_req);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_ready && !rec_valid) |=> (!done_valid && !flush_valid));

endmodule

bind retire_load_verifier retire_load_verifier_chk #(.AGE_W(AGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_skip(rec_skip),
  .rec_age(rec_age), .rec_ready(rec_ready), .mem_req(mem_req),
  .done_valid(done_valid), .done_age(done_age), .flush_valid(flush_valid)
);

// File: tb/retire_load_verifier_tb.sv
module retire_load_verifier_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int GW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rec_valid = 1'b0;
  logic          rec_skip = 1'b0;
  logic [AW-1:0] rec_addr = '0;
  logic [DW-1:0] rec_value = '0;
  logic [GW-1:0] rec_age = '0;
  logic          rec_ready;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          done_valid;
  logic [GW-1:0] done_age;
  logic [DW-1:0] done_data;
  logic          flush_valid;
  logic [GW-1:0] flush_age;
  logic [DW-1:0] flush_data;

  logic [DW-1:0] mem [16];
  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [GW-1:0] next_age = '0;

  always #2.5 clk = ~clk;

  retire_load_verifier #(.ADDR_W(AW), .DATA_W(DW), .AGE_W(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_skip(rec_skip),
    .rec_addr(rec_addr), .rec_value(rec_value), .rec_age(rec_age),
    .rec_ready(rec_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done_valid(done_valid), .done_age(done_age),
    .done_data(done_data), .flush_valid(flush_valid), .flush_age(flush_age),
    .flush_data(flush_data)
  );

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit expect_flush(input bit skip, input logic [DW-1:0] saved,
                                      input logic [DW-1:0] held);
    return !skip && (saved != held);
  endfunction

  task automatic run_load(input logic [AW-1:0] a, input logic [DW-1:0] v,
                          input bit skip, input bit probe_flush);
    logic [DW-1:0] held;
    bit fl;
    logic [GW-1:0] g;
    g = next_age;
    next_age = next_age + 1'b1;
    held = mem[a];
    fl = expect_flush(skip, v, held);
    @(negedge clk);
    rec_valid = 1'b1; rec_skip = skip; rec_addr = a; rec_value = v; rec_age = g;
    #1;
    chk(rec_ready == 1'b1, "R2 ready before accept", int'(rec_ready), 1);
    chk(mem_req == !skip, skip ? "R6 no read" : "R2 read issued", int'(mem_req), int'(!skip));
    if (!skip) chk(mem_addr == a, "R2 read address", int'(mem_addr), int'(a));
    @(negedge clk);
    rec_valid = 1'b0;
    #1;
    if (skip) begin
      chk(done_valid && !flush_valid, "R6 skip retires", int'(done_valid), 1);
      chk(done_age == g && done_data == v, "R6 skip data", int'(done_data), int'(v));
      return;
    end
    chk(!rec_ready && !done_valid && !flush_valid, "R2 hold", int'(rec_ready), 0);
    @(negedge clk);
    if (probe_flush) begin
      rec_valid = 1'b1; rec_skip = 1'b0;
    end
    #1;
    chk(flush_valid == fl, fl ? "R4 flush" : "R3 no flush", int'(flush_valid), int'(fl));
    chk(done_valid == !fl, "R9 single outcome", int'(done_valid), int'(!fl));
    if (fl) begin
      chk(flush_age == g, "R4 flush age", int'(flush_age), int'(g));
      chk(flush_data == held, "R4 corrected data", int'(flush_data), int'(held));
      if (probe_flush) begin
        chk(!rec_ready && !mem_req, "R7 stall on flush", int'(mem_req), 0);
      end
    end else begin
      chk(done_age == g, "R3 retire age", int'(done_age), int'(g));
      chk(done_data == v, "R3 retire data", int'(done_data), int'(v));
    end
    rec_valid = 1'b0;
    @(negedge clk);
    #1;
    chk(!done_valid && !flush_valid, "R8 quiet", int'(done_valid | flush_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mem[i] = DW'($urandom);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(rec_ready && !mem_req && !done_valid && !flush_valid, "R1 reset state",
        int'(rec_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(rec_ready && !done_valid && !flush_valid, "R1 after reset", int'(rec_ready), 1);

    run_load(4'd3, mem[3], 1'b0, 1'b0);
    run_load(4'd5, mem[5] ^ 8'h21, 1'b0, 1'b1);
    mem[7] = mem[7];
    run_load(4'd7, mem[7], 1'b0, 1'b0);
    chk(1'b1, "R5 same-value rewrite no flush", 0, 0);
    run_load(4'd9, mem[9] ^ 8'h80, 1'b1, 1'b0);

    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] v;
      int kind;
      a = AW'($urandom % 16);
      kind = $urandom % 3;
      if (kind == 2) mem[a] = mem[a];
      if ($urandom % 5 == 0) mem[AW'($urandom % 16)] = DW'($urandom);
      v = (kind == 1) ? (mem[a] ^ DW'(1 + $urandom % 255)) : mem[a];
      run_load(a, v, ($urandom % 4) == 0, ($urandom % 2) == 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule